// File: doc/BRIEF.md
# SPI Receive DMA Count Capture

This block keeps the bookkeeping for a receive DMA channel with two buffers, A and B, fed by an SPI slave. It tracks which buffer is active, how many bytes have gone into each buffer, and when a buffer is used up. When the buffer is full, the channel moves to the other buffer. When the active-low select line goes high, the block can freeze the active buffer's byte count so software can see how long the finished frame was.

Only the first select rising edge after a buffer load takes a snapshot. Later edges leave the snapshot alone and only set a flag in a 3-bit status field. The status field also tells which buffer the snapshot came from.

A receive overflow is held back and only reported as a DMA error once the receive FIFO has drained. The error can be cleared by the channel reset strobe. It can also be cleared by reloading a buffer that has finished since it was last loaded.

Top module: `spi_rxdma_capture`

## Requirements
- R1: The select pin is synchronized by two flops and its rising edge is detected from the synchronized copy. A pin rise set up before clock edge k updates the outputs at edge k+2 and no earlier.
- R2: The first select rising edge after any buffer load copies the active buffer's count into `saved_cnt` and writes the status to 3'b001 if buffer A is active or 3'b010 if buffer B is active.
- R3: Status bit 0 means the count came from buffer A, bit 1 means from buffer B, and bit 2 means an extra rising edge was seen. Bits 0 and 1 are never set together.
- R4: A select rising edge with no load since the last snapshot leaves `saved_cnt` unchanged and sets status bit 2.
- R5: A pulse on `load_a` or `load_b` clears the status to 0 and re-arms the snapshot. When a load and a select edge land in the same cycle, the load wins: nothing is captured and the next edge captures.
- R6: A load sets that buffer's count to 0 and marks it loaded. Each `byte_strobe` adds one to the active buffer's count only if that buffer is loaded. When the count reaches the buffer's length, the buffer unloads and the other buffer becomes active. After reset buffer A is active.
- R7: `ovf_evt` does not raise `rx_err` directly. `rx_err` goes high one cycle after `fifo_empty` is seen high, at any cycle after the overflow.
- R8: Loading a buffer that has unloaded since its last load clears `rx_err`. Loading a buffer that is still loaded leaves `rx_err` as it is.
- R9: `rst_n` low, or a `dma_rst` pulse, returns the block to its reset state: `saved_cnt` = 0, status = 0, `rx_err` = 0, no pending overflow, both buffers unloaded, and buffer A active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sel_n_pin | input | 1 | SPI slave select, active low, asynchronous |
| byte_strobe | input | 1 | One received byte stored by the DMA |
| load_a | input | 1 | Buffer A load pulse |
| load_b | input | 1 | Buffer B load pulse |
| len_a | input | CNT_W | Buffer A length in bytes |
| len_b | input | CNT_W | Buffer B length in bytes |
| fifo_empty | input | 1 | Receive FIFO is empty |
| ovf_evt | input | 1 | Receive FIFO overflow pulse |
| dma_rst | input | 1 | Receive channel reset pulse |
| saved_cnt | output | CNT_W | Snapshot of the active count |
| sel_status | output | 3 | Snapshot and extra-edge status |
| rx_err | output | 1 | Receive DMA error |

## Verification
Loads, resets and error changes show up one clock after the input is sampled. Select-edge results show up three clocks after the pin changes: two synchronizer flops, then the update register. Each expected item is queued with the exact cycle it is due. The monitor compares it at the falling edge of that cycle and reports an item that arrives late. For the select path, an extra item one cycle earlier confirms the old value still holds at that point. A load is also timed to land in the same cycle as the edge, to check that the load wins.

// File: rtl/spi_rxdma_capture.sv
module spi_rxdma_capture #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sel_n_pin,
  input  logic             byte_strobe,
  input  logic             load_a,
  input  logic             load_b,
  input  logic [CNT_W-1:0] len_a,
  input  logic [CNT_W-1:0] len_b,
  input  logic             fifo_empty,
  input  logic             ovf_evt,
  input  logic             dma_rst,
  output logic [CNT_W-1:0] saved_cnt,
  output logic [2:0]       sel_status,
  output logic             rx_err
);

  logic s1, s2, s3;
  logic act_b, ld_a, ld_b, done_a, done_b, arm, pend;
  logic [CNT_W-1:0] cnt_a, cnt_b;

  wire             rise     = s2 & ~s3;
  wire [CNT_W-1:0] act_cnt  = act_b ? cnt_b : cnt_a;
  wire [CNT_W-1:0] act_len  = act_b ? len_b : len_a;
  wire             act_ld   = act_b ? ld_b : ld_a;
  wire             act_load = act_b ? load_b : load_a;
  wire [CNT_W-1:0] nxt      = act_cnt + 1'b1;
  wire             take     = byte_strobe & act_ld & ~act_load;
  wire             wrap     = take & (nxt == act_len);
  wire             any_load = load_a | load_b;
  wire             err_set  = pend & fifo_empty;
  wire             err_clr  = (load_a & done_a) | (load_b & done_b);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) {s1, s2, s3} <= 3'b111;
    else        {s1, s2, s3} <= {sel_n_pin, s1, s2};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_b <= 1'b0;
      ld_a <= 1'b0; ld_b <= 1'b0; done_a <= 1'b0; done_b <= 1'b0;
      cnt_a <= '0;  cnt_b <= '0;
    end else if (dma_rst) begin
      act_b <= 1'b0;
      ld_a <= 1'b0; ld_b <= 1'b0; done_a <= 1'b0; done_b <= 1'b0;
      cnt_a <= '0;  cnt_b <= '0;
    end else begin
      if (load_a) begin
        cnt_a <= '0; ld_a <= 1'b1; done_a <= 1'b0;
      end else if (take && !act_b) begin
        cnt_a <= nxt;
        if (wrap) begin ld_a <= 1'b0; done_a <= 1'b1; end
      end
      if (load_b) begin
        cnt_b <= '0; ld_b <= 1'b1; done_b <= 1'b0;
      end else if (take && act_b) begin
        cnt_b <= nxt;
        if (wrap) begin ld_b <= 1'b0; done_b <= 1'b1; end
      end
      if (wrap) act_b <= ~act_b;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      saved_cnt <= '0; sel_status <= '0; arm <= 1'b0;
    end else if (dma_rst) begin
      saved_cnt <= '0; sel_status <= '0; arm <= 1'b0;
    end else if (any_load) begin
      sel_status <= '0; arm <= 1'b1;
    end else if (rise && arm) begin
      saved_cnt  <= act_cnt;
      sel_status <= act_b ? 3'b010 : 3'b001;
      arm        <= 1'b0;
    end else if (rise) begin
      sel_status[2] <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend <= 1'b0; rx_err <= 1'b0;
    end else if (dma_rst) begin
      pend <= 1'b0; rx_err <= 1'b0;
    end else begin
      pend <= (pend & ~fifo_empty) | ovf_evt;
      if (err_set)      rx_err <= 1'b1;
      else if (err_clr) rx_err <= 1'b0;
    end
  end

endmodule

// File: rtl/spi_rxdma_capture_chk.sv
module spi_rxdma_capture_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rise,
  input logic             arm,
  input logic             load_a,
  input logic             load_b,
  input logic             fifo_empty,
  input logic             dma_rst,
  input logic [CNT_W-1:0] saved_cnt,
  input logic [2:0]       sel_status,
  input logic             rx_err
);

  p_src_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(sel_status[1:0]) <= 1);

  p_hold_saved_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!rise && !dma_rst) |=> $stable(saved_cnt));

  p_extra_edge_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rise && !arm && !load_a && !load_b && !dma_rst) |=> sel_status[2]);

  p_load_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((load_a || load_b) && !dma_rst) |=> (sel_status == 3'b000));

  p_err_after_drain_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_err) |-> $past(fifo_empty));

  p_chan_reset_r9: assert property (@(posedge clk) disable iff (!rst_n)
    dma_rst |=> (!rx_err && sel_status == 3'b000 && saved_cnt == '0));

endmodule

bind spi_rxdma_capture spi_rxdma_capture_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .rise(rise), .arm(arm),
  .load_a(load_a), .load_b(load_b), .fifo_empty(fifo_empty), .dma_rst(dma_rst),
  .saved_cnt(saved_cnt), .sel_status(sel_status), .rx_err(rx_err)
);

// File: tb/spi_rxdma_capture_bench.sv
module spi_rxdma_capture_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sel_n_pin = 1'b1, byte_strobe = 1'b0, load_a = 1'b0, load_b = 1'b0;
  logic fifo_empty = 1'b0, ovf_evt = 1'b0, dma_rst = 1'b0;
  logic [15:0] len_a = 16'd5, len_b = 16'd3;
  logic [15:0] saved_cnt;
  logic [2:0]  sel_status;
  logic        rx_err;

  always #2.5 clk = ~clk;

  spi_rxdma_capture u_spi_rxdma_capture (.*);

  typedef struct { int due; string req; logic [15:0] sv; logic [2:0] st; logic er; } item_t;
  item_t q[$];
  int cyc = 0, checks = 0, bad = 0;
  bit finished = 0;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk)
    while (q.size() > 0 && q[0].due <= cyc) begin
      item_t it;
      it = q.pop_front();
      checks++;
      if (it.due != cyc || saved_cnt !== it.sv || sel_status !== it.st || rx_err !== it.er) begin
        bad++;
        $display("FAIL %s cyc=%0d due=%0d: got saved=%0d status=%b err=%b, expected saved=%0d status=%b err=%b",
                 it.req, cyc, it.due, saved_cnt, sel_status, rx_err, it.sv, it.st, it.er);
      end
    end

  task automatic step(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_at(int d, string r, logic [15:0] sv, logic [2:0] st, logic er);
    q.push_back('{cyc + d, r, sv, st, er});
  endtask

  task automatic bytes(int n);
    byte_strobe = 1'b1; step(n); byte_strobe = 1'b0;
  endtask

  task automatic sel_rise(string r, logic [15:0] osv, logic [2:0] ost, logic oer,
                          logic [15:0] sv, logic [2:0] st, logic er);
    sel_n_pin = 1'b0; step(4);
    sel_n_pin = 1'b1;
    expect_at(2, "R1", osv, ost, oer);
    expect_at(3, r, sv, st, er);
    step(5);
  endtask

  initial begin
    step(3);
    rst_n = 1'b1;
    expect_at(1, "R9", 16'd0, 3'b000, 1'b0);
    step(2);

    load_a = 1'b1; expect_at(1, "R5", 16'd0, 3'b000, 1'b0); step(); load_a = 1'b0;
    bytes(3);
    sel_rise("R2", 16'd0, 3'b000, 1'b0, 16'd3, 3'b001, 1'b0);
    sel_rise("R4", 16'd3, 3'b001, 1'b0, 16'd3, 3'b101, 1'b0);

    load_b = 1'b1; expect_at(1, "R5", 16'd3, 3'b000, 1'b0); step(); load_b = 1'b0;
    bytes(2);
    bytes(2);
    sel_rise("R6", 16'd3, 3'b000, 1'b0, 16'd2, 3'b010, 1'b0);

    bytes(1);
    bytes(2);
    sel_n_pin = 1'b0; step(4);
    sel_n_pin = 1'b1; step(2);
    load_b = 1'b1; expect_at(1, "R5", 16'd2, 3'b000, 1'b0); step(); load_b = 1'b0;
    step(4);
    sel_rise("R6", 16'd2, 3'b000, 1'b0, 16'd5, 3'b001, 1'b0);

    ovf_evt = 1'b1; step(); ovf_evt = 1'b0;
    step(3);
    expect_at(1, "R7", 16'd5, 3'b001, 1'b0); step();
    fifo_empty = 1'b1; expect_at(1, "R7", 16'd5, 3'b001, 1'b1); step(); fifo_empty = 1'b0;
    step();
    load_b = 1'b1; expect_at(1, "R8", 16'd5, 3'b000, 1'b1); step(); load_b = 1'b0;
    load_a = 1'b1; expect_at(1, "R8", 16'd5, 3'b000, 1'b0); step(); load_a = 1'b0;

    ovf_evt = 1'b1; step(); ovf_evt = 1'b0;
    fifo_empty = 1'b1; expect_at(1, "R7", 16'd5, 3'b000, 1'b1); step(); fifo_empty = 1'b0;
    step();
    dma_rst = 1'b1; expect_at(1, "R9", 16'd0, 3'b000, 1'b0); step(); dma_rst = 1'b0;
    step(4);

    finished = 1;
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    #(5ns * 5000);
    if (!finished) begin
      checks++; bad++;
      $display("FAIL watchdog: got hung run, expected completion");
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end
endmodule